// File: doc/BRIEF.md
# Manchester Bit Clock Recovery with Fast Preamble Lock

This block recovers a bit-rate strobe and the data bit from a filtered, Manchester-coded serial line. It runs on a system clock at sixteen times the nominal bit rate. A free-running phase counter of sixteen steps marks time within one bit. Phase 8 is where the mid-bit transition should fall, and phase 12 is the sample point.

A level input from a line-activity detector frames each message. When activity appears, the block enters a fast-lock phase. In that phase the phase counter is forced to a fixed value when the fourth line transition arrives, or optionally on each of the first four transitions. After that the block switches to a tracking loop that stays in force until activity drops. The tracking loop moves the phase by at most one count per mid-bit transition. It ignores transitions at bit boundaries.

An optional refinement measures the last high and the last low run before the fourth transition. It shifts the forced phase by their mean minus one bit period. A polarity input from the downstream decoder selects whether the data output carries the second-half level or its inverse.

Top module: `manch_clk_recover`

## Requirements
- R1: While `rst` is high, `bit_strobe`, `rx_data` and `locked` are 0 at the next clock and stay 0, whatever `line_active` and `rx_in` do.
- R2: When `line_active` rises, the phase counter restarts from 0. Until lock, a one-cycle `bit_strobe` then appears 14 cycles after `line_active` is driven high, and every 16 cycles after that.
- R3: With `sync_each`=0, the fourth `rx_in` transition after activity starts forces the phase to the lock value. `bit_strobe` pulses 6 cycles after that transition is driven, and `locked` goes to 1.
- R4: With `sync_each`=1, each of the first four transitions forces the phase. The first strobe then follows the first transition by 6 cycles.
- R5: While locked, a transition seen at phase 4..12 moves the phase as follows: one extra step if it is seen before phase 8, a held count if it is seen after phase 8, no change at phase 8. The spacing between strobes therefore stays within 15..17 cycles. A mid-bit edge arriving 3 cycles early shifts the strobe by exactly 1 cycle.
- R6: While locked, transitions seen at phases 13..15 and 0..3 (the bit boundaries) do not move the phase.
- R7: With `fine_en`=1, the lock value is moved back by (H+L)/2−16 counts, truncated. H and L are the last high and last low run lengths before the fourth transition, each saturating at 31. Each extra count delays the strobe by one cycle.
- R8: At each strobe, `rx_data` equals the line level in the second half of the bit XOR `polarity`, and it holds its value between strobes.
- R9: A falling `line_active` returns the block to idle within one cycle. No strobe appears from 2 cycles after the fall, and `locked` is 0. Tracking is never left while activity is high, and the next rise starts a fresh fast-lock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at 16x bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_active | input | 1 | Line-activity level; high for the length of a message |
| rx_in | input | 1 | Filtered Manchester line |
| polarity | input | 1 | 1 inverts the sampled data |
| sync_each | input | 1 | 1 forces the phase on each of the first four transitions |
| fine_en | input | 1 | 1 enables the run-length correction of the lock phase |
| bit_strobe | output | 1 | One-cycle pulse at the recovered sample point |
| rx_data | output | 1 | Data bit captured at the last strobe |
| locked | output | 1 | 1 while in tracking mode |

## Verification
The hardest state to reach is a locked loop that sees a mid-bit edge off its nominal phase. Phase errors must be built by hand, because a well-formed preamble always lands the counter exactly on centre. The bench therefore shapes individual half-bits cycle by cycle. It shortens one first half by three cycles to make an early edge. It stretches every bit to 17 cycles to make a drift of one count per bit. It also lengthens the preamble runs, up to one run beyond the 31-cycle saturation limit. It then compares strobe positions against timings derived from the requirements.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QUICK = 2'd1,
    ST_TRACK = 2'd2
  } mcr_state_e;

endpackage

// File: rtl/mcr_edge_det.sv
module mcr_edge_det #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_s_o,
  output logic rx_d_o,
  output logic edge_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= rx_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], rx_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[SYNC_STAGES-1];
  end

  assign rx_s_o = chain_q[SYNC_STAGES-1];
  assign rx_d_o = last_q;
  assign edge_o = chain_q[SYNC_STAGES-1] ^ last_q;

endmodule

// File: rtl/mcr_width_meas.sv
module mcr_width_meas #(
  parameter int OSR   = 16,
  parameter int LEN_W = 5,
  localparam int PH_W = $clog2(OSR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            edge_i,
  input  logic            lvl_prev_i,
  output logic [PH_W-1:0] corr_o
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] OSR_L   = LEN_W'(OSR);
  localparam logic [LEN_W-1:0] ONE_L   = LEN_W'(1);

  logic [LEN_W-1:0] run_q;
  logic [LEN_W-1:0] hi_q;
  logic [LEN_W-1:0] lo_q;
  logic [LEN_W-1:0] hi_eff;
  logic [LEN_W-1:0] lo_eff;
  logic [LEN_W-1:0] mean;

  // run length since the last transition, saturating
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      run_q <= '0;
    end else if (edge_i) begin
      run_q <= ONE_L;
    end else if (run_q != LEN_MAX) begin
      run_q <= run_q + ONE_L;
    end
  end

  // store the run that just ended under its level
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (edge_i) begin
      if (lvl_prev_i) hi_q <= run_q;
      else            lo_q <= run_q;
    end
  end

  // the run ending on this very edge is taken directly
  always_comb begin
    hi_eff = (edge_i && lvl_prev_i)  ? run_q : hi_q;
    lo_eff = (edge_i && !lvl_prev_i) ? run_q : lo_q;
    mean   = LEN_W'(({1'b0, hi_eff} + {1'b0, lo_eff}) >> 1);
    corr_o = PH_W'(mean - OSR_L);
  end

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!edge_i && !clr_i) |=> ($stable(hi_q) && $stable(lo_q))); // R7

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
    (edge_i && !clr_i) |=> (run_q == ONE_L)); // R7

endmodule

// File: rtl/mcr_phase_ctrl.sv
module mcr_phase_ctrl
  import mcr_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int NSYNC = 4,
  localparam int PH_W = $clog2(OSR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_active,
  input  logic            edge_i,
  input  logic            sync_each,
  input  logic            fine_en,
  input  logic [PH_W-1:0] corr_i,
  output logic            samp_en_o,
  output logic            idle_o,
  output logic            locked_o
);

  localparam int ECNT_W = $clog2(NSYNC + 1);
  localparam logic [PH_W-1:0]   CENTER_L = PH_W'(OSR / 2);
  localparam logic [PH_W-1:0]   BASE_L   = PH_W'(OSR / 2 + 1);
  localparam logic [PH_W-1:0]   SAMPLE_L = PH_W'(OSR / 2 + OSR / 4);
  localparam logic [PH_W-1:0]   WLO_L    = PH_W'(OSR / 4);
  localparam logic [PH_W-1:0]   WHI_L    = PH_W'(3 * OSR / 4);
  localparam logic [PH_W-1:0]   STEP1    = PH_W'(1);
  localparam logic [PH_W-1:0]   STEP2    = PH_W'(2);
  localparam logic [ECNT_W-1:0] ELAST    = ECNT_W'(NSYNC - 1);
  localparam logic [ECNT_W-1:0] EONE     = ECNT_W'(1);

  mcr_state_e       st_q;
  logic [PH_W-1:0]  ph_q;
  logic [ECNT_W-1:0] ecnt_q;
  logic [PH_W-1:0]  load_val;
  logic [PH_W-1:0]  track_step;
  logic             in_win;

  always_comb begin
    load_val = BASE_L - (fine_en ? corr_i : '0);
    in_win   = (ph_q >= WLO_L) && (ph_q <= WHI_L);
    if (ph_q < CENTER_L)      track_step = STEP2;
    else if (ph_q > CENTER_L) track_step = '0;
    else                      track_step = STEP1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      ecnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          ph_q   <= '0;
          ecnt_q <= '0;
          if (line_active) st_q <= ST_QUICK;
        end
        ST_QUICK: begin
          if (!line_active) begin
            st_q <= ST_IDLE;
            ph_q <= '0;
          end else if (edge_i) begin
            ecnt_q <= ecnt_q + EONE;
            if (ecnt_q == ELAST) begin
              ph_q <= load_val;
              st_q <= ST_TRACK;
            end else if (sync_each) begin
              ph_q <= BASE_L;
            end else begin
              ph_q <= ph_q + STEP1;
            end
          end else begin
            ph_q <= ph_q + STEP1;
          end
        end
        ST_TRACK: begin
          if (!line_active) begin
            st_q <= ST_IDLE;
            ph_q <= '0;
          end else if (edge_i && in_win) begin
            ph_q <= ph_q + track_step;
          end else begin
            ph_q <= ph_q + STEP1;
          end
        end
        default: begin
          st_q <= ST_IDLE;
          ph_q <= '0;
        end
      endcase
    end
  end

  assign samp_en_o = (st_q != ST_IDLE) && (ph_q == SAMPLE_L);
  assign idle_o    = (st_q == ST_IDLE);
  assign locked_o  = (st_q == ST_TRACK);

  AST_PH_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TRACK && $past(st_q) == ST_TRACK) |-> (PH_W'(ph_q - $past(ph_q)) <= STEP2)); // R5

  AST_TRACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TRACK && line_active) |=> (st_q == ST_TRACK)); // R9

  AST_LOCK_EDGE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TRACK && $past(st_q) == ST_QUICK) |-> ($past(edge_i) && $past(ecnt_q) == ELAST)); // R3

  AST_FALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!line_active && st_q != ST_IDLE) |=> (st_q == ST_IDLE)); // R9

endmodule

// File: rtl/mcr_data_slicer.sv
module mcr_data_slicer (
  input  logic clk,
  input  logic rst,
  input  logic samp_en_i,
  input  logic rx_s_i,
  input  logic polarity,
  output logic bit_strobe_o,
  output logic rx_data_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_strobe_o <= 1'b0;
      rx_data_o    <= 1'b0;
    end else begin
      bit_strobe_o <= samp_en_i;
      if (samp_en_i) rx_data_o <= rx_s_i ^ polarity;
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_strobe_o |-> $stable(rx_data_o)); // R8

endmodule

// File: rtl/manch_clk_recover.sv
module manch_clk_recover #(
  parameter int OSR         = 16,
  parameter int NSYNC       = 4,
  parameter int LEN_W       = 5,
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_active,
  input  logic rx_in,
  input  logic polarity,
  input  logic sync_each,
  input  logic fine_en,
  output logic bit_strobe,
  output logic rx_data,
  output logic locked
);

  localparam int PH_W = $clog2(OSR);

  logic            rx_s;
  logic            rx_d;
  logic            line_edge;
  logic [PH_W-1:0] corr;
  logic            samp_en;
  logic            idle;

  mcr_edge_det #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst    (rst),
    .rx_in  (rx_in),
    .rx_s_o (rx_s),
    .rx_d_o (rx_d),
    .edge_o (line_edge)
  );

  mcr_width_meas #(
    .OSR   (OSR),
    .LEN_W (LEN_W)
  ) u_width (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (idle),
    .edge_i     (line_edge),
    .lvl_prev_i (rx_d),
    .corr_o     (corr)
  );

  mcr_phase_ctrl #(
    .OSR   (OSR),
    .NSYNC (NSYNC)
  ) u_phase (
    .clk         (clk),
    .rst         (rst),
    .line_active (line_active),
    .edge_i      (line_edge),
    .sync_each   (sync_each),
    .fine_en     (fine_en),
    .corr_i      (corr),
    .samp_en_o   (samp_en),
    .idle_o      (idle),
    .locked_o    (locked)
  );

  mcr_data_slicer u_slice (
    .clk          (clk),
    .rst          (rst),
    .samp_en_i    (samp_en),
    .rx_s_i       (rx_s),
    .polarity     (polarity),
    .bit_strobe_o (bit_strobe),
    .rx_data_o    (rx_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!bit_strobe && !locked)); // R1

  AST_NO_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> !$past(idle)); // R9

endmodule

// File: tb/sim_manch_clk_recover.sv
module sim_manch_clk_recover;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_active = 1'b0;
  logic rx_in = 1'b0;
  logic polarity = 1'b0;
  logic sync_each = 1'b0;
  logic fine_en = 1'b0;
  logic bit_strobe;
  logic rx_data;
  logic locked;

  always #10 clk = ~clk;

  manch_clk_recover u0 (
    .clk         (clk),
    .rst         (rst),
    .line_active (line_active),
    .rx_in       (rx_in),
    .polarity    (polarity),
    .sync_each   (sync_each),
    .fine_en     (fine_en),
    .bit_strobe  (bit_strobe),
    .rx_data     (rx_data),
    .locked      (locked)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int s_cyc[$];
  bit s_dat[$];
  always @(negedge clk) begin
    if (bit_strobe) begin
      s_cyc.push_back(cyc);
      s_dat.push_back(rx_data);
    end
  end

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit strobe_at(input int c);
    foreach (s_cyc[i]) if (s_cyc[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int data_at(input int c);
    foreach (s_cyc[i]) if (s_cyc[i] == c) return int'(s_dat[i]);
    return -1;
  endfunction

  task automatic half(input bit lvl, input int n);
    rx_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int h1, input int h2, output int c);
    half(~b, h1);
    c = cyc;
    half(b, h2);
  endtask

  task automatic start_msg(input bit se, input bit fe, input bit pol, output int a);
    sync_each = se;
    fine_en = fe;
    polarity = pol;
    rx_in = 1'b0;
    s_cyc.delete();
    s_dat.delete();
    line_active = 1'b1;
    a = cyc;
  endtask

  task automatic preamble(output int e4);
    int c;
    send_bit(1'b1, 16, 8, c);
    send_bit(1'b0, 8, 8, c);
    send_bit(1'b1, 8, 8, c);
    send_bit(1'b0, 8, 8, e4);
  endtask

  task automatic end_msg(input string req);
    int f;
    int late;
    line_active = 1'b0;
    f = cyc;
    half(1'b1, 10);
    half(1'b0, 14);
    late = 0;
    foreach (s_cyc[i]) if (s_cyc[i] >= f + 2) late++;
    chk(late == 0, req, "strobes after activity fell", late, 0);
    chk(locked == 1'b0, req, "locked after activity fell", locked, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    line_active = 1'b1;
    repeat (20) begin
      @(negedge clk);
      rx_in = ~rx_in;
      chk(bit_strobe == 1'b0, "R1", "bit_strobe in reset", bit_strobe, 0);
    end
    chk(rx_data == 1'b0, "R1", "rx_data in reset", rx_data, 0);
    chk(locked == 1'b0, "R1", "locked in reset", locked, 0);
    line_active = 1'b0;
    rx_in = 1'b0;
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_lock_default();
    int a, e4, c;
    bit bits[6] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    int cen[6];
    start_msg(1'b0, 1'b0, 1'b0, a);
    send_bit(1'b1, 16, 8, c);
    send_bit(1'b0, 8, 8, c);
    send_bit(1'b1, 8, 8, c);
    chk(locked == 1'b0, "R3", "locked before fourth edge", locked, 0);
    send_bit(1'b0, 8, 8, e4);
    chk(strobe_at(a + 14) && strobe_at(a + 30), "R2", "free-running strobe", 0, 1);
    for (int k = 0; k < 6; k++) send_bit(bits[k], 8, 8, cen[k]);
    half(rx_in, 8);
    chk(strobe_at(e4 + 6), "R3", "lock strobe offset", 0, 1);
    chk(!strobe_at(e4 + 14), "R3", "old free grid after lock", 1, 0);
    chk(locked == 1'b1, "R3", "locked after fourth edge", locked, 1);
    for (int k = 0; k < 6; k++) begin
      chk(strobe_at(cen[k] + 6), "R6", "strobe stays at centre+6", 0, 1);
      chk(data_at(cen[k] + 6) == int'(bits[k]), "R8", "data bit",
          data_at(cen[k] + 6), int'(bits[k]));
    end
    end_msg("R9");
  endtask

  task automatic t_lock_each();
    int a, e4, c;
    bit bits[4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    int cen[4];
    start_msg(1'b1, 1'b0, 1'b1, a);
    preamble(e4);
    for (int k = 0; k < 4; k++) send_bit(bits[k], 8, 8, cen[k]);
    half(rx_in, 8);
    chk(strobe_at(a + 22), "R4", "strobe after first edge", 0, 1);
    chk(!strobe_at(a + 30), "R4", "free grid not kept", 1, 0);
    for (int k = 0; k < 4; k++)
      chk(data_at(cen[k] + 6) == int'(!bits[k]), "R8", "inverted data",
          data_at(cen[k] + 6), int'(!bits[k]));
    end_msg("R9");
  endtask

  task automatic t_slow();
    int a, e4, c, n, bad_gap, bad_dat;
    bit bits[20];
    bit exp_d[$];
    int got_c[$];
    bit got_d[$];
    start_msg(1'b0, 1'b0, 1'b0, a);
    preamble(e4);
    exp_d.push_back(1'b0);
    for (int k = 0; k < 20; k++) begin
      bits[k] = ((k * 7 + 3) % 5) < 2;
      exp_d.push_back(bits[k]);
      send_bit(bits[k], 8, 9, c);
    end
    half(rx_in, 6);
    foreach (s_cyc[i]) if (s_cyc[i] > e4) begin
      got_c.push_back(s_cyc[i]);
      got_d.push_back(s_dat[i]);
    end
    n = got_c.size();
    chk(n == 21, "R5", "strobe count at 17-cycle bits", n, 21);
    bad_gap = 0;
    bad_dat = 0;
    for (int i = 1; i < n; i++)
      if (got_c[i] - got_c[i-1] < 15 || got_c[i] - got_c[i-1] > 17) bad_gap++;
    for (int i = 0; i < n && i < 21; i++) if (got_d[i] != exp_d[i]) bad_dat++;
    chk(bad_gap == 0, "R5", "strobe gaps outside 15..17", bad_gap, 0);
    chk(bad_dat == 0, "R8", "data errors at slow rate", bad_dat, 0);
    end_msg("R9");
  endtask

  task automatic t_early();
    int a, e4, c, s, c2;
    start_msg(1'b0, 1'b0, 1'b0, a);
    preamble(e4);
    send_bit(1'b1, 8, 8, c);
    send_bit(1'b1, 8, 8, c);
    s = cyc;
    send_bit(1'b0, 5, 11, c);
    send_bit(1'b1, 8, 8, c2);
    half(rx_in, 8);
    chk(strobe_at(s + 13), "R5", "early edge shifts strobe by one", 0, 1);
    chk(!strobe_at(s + 11) && !strobe_at(s + 14), "R5", "no full or zero shift", 1, 0);
    chk(strobe_at(c2 + 6), "R5", "recentred on next bit", 0, 1);
    chk(locked == 1'b1, "R9", "still locked after disturbance", locked, 1);
    end_msg("R9");
  endtask

  task automatic t_fine(input bit fe, input int l1, input int h2,
                        input int delay, input int bad_delay);
    int a, e4;
    start_msg(1'b0, fe, 1'b0, a);
    half(1'b0, 8);
    half(1'b1, 16);
    half(1'b0, l1);
    half(1'b1, h2);
    e4 = cyc;
    half(1'b0, 24);
    chk(strobe_at(e4 + delay), "R7", "lock strobe with run correction", 0, delay);
    chk(!strobe_at(e4 + bad_delay), "R7", "strobe at wrong offset", 1, 0);
    end_msg("R9");
  endtask

  initial begin
    t_reset();
    t_lock_default();
    t_lock_each();
    t_slow();
    t_early();
    t_fine(1'b0, 18, 18, 6, 8);
    t_fine(1'b1, 18, 18, 8, 6);
    t_fine(1'b1, 16, 40, 13, 18);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule